// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does so by reading a two-level translation table that lives in a word-addressed memory. A requester hands it three things: the virtual address, a read/write flag and the frame number of the root table. The walker then reads one root entry and one secondary entry through a single request/response memory port.

It answers with one of two results:
- the physical address together with the final entry, or
- a fault code together with the virtual address that caused it.

After a successful access, the walker writes the referenced bit, and for a write also the modified bit, back into the leaf entry in memory. It skips that write when both bits are already set.

The walker serves one translation at a time. It is ready for a new request only when idle. It holds each answer until the requester acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a root index in bits 31:22, a secondary index in bits 21:12 and a byte offset in bits 11:0. The first memory read targets word address {root frame, root index}, which is byte address root base plus four times the root index.
- R2: An entry holds a frame number in bits 31:12 and status flags in bit 0 (present), bit 1 (writable), bit 2 (referenced) and bit 3 (modified). The second read targets word address {frame of the root entry, secondary index}.
- R3: A successful walk answers with status 2'b00 and physical address {leaf frame, offset}.
- R4: A root entry with bit 0 clear ends the walk after exactly one memory read. The answer carries status 2'b01, the faulting virtual address and the root entry.
- R5: A leaf entry with bit 0 clear ends the walk with status 2'b10 and the faulting virtual address. Memory is not written.
- R6: A write to a present leaf whose bit 1 is clear answers status 2'b11 and leaves the entry in memory unchanged.
- R7: A successful read sets bit 2 of the leaf entry. A successful write sets bits 2 and 3. The updated entry is written back to the leaf's word address and returned as the answer's entry.
- R8: When the leaf already holds the bits a successful access needs, no memory write is issued.
- R9: The request port is ready only while idle; a request offered while busy is ignored. The answer stays valid and unchanged until it is acknowledged, and it drops in the cycle after the acknowledge.
- R10: A memory request that is not accepted stays asserted with unchanged address, write flag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken this cycle if offered |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_root_frame | input | 20 | Frame number of the root table |
| mem_req_valid | output | 1 | Memory access requested |
| mem_req_ready | input | 1 | Memory accepts the access this cycle |
| mem_req_we | output | 1 | 1 = write-back of an entry, 0 = read |
| mem_req_addr | output | 30 | Word address of the entry |
| mem_req_wdata | output | 32 | Entry value to write |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry word |
| rsp_valid | output | 1 | Answer available |
| rsp_ack | input | 1 | Requester takes the answer |
| rsp_status | output | 2 | 00 ok, 01 root absent, 10 leaf absent, 11 protection |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_pte | output | 32 | Entry that ended the walk, with updated flags |

## Verification
Two cases are hard to reach from the ports. The first is a skipped write-back: it happens only when the leaf already holds exactly the flags the access needs. The second is a request offered while the walker is busy.

The bench reaches the first case in two ways. It repeats an access to a page that an earlier walk has just marked. It also fills a secondary table with every mix of present, writable, referenced and modified flags and sweeps random reads and writes across that table. The memory model counts reads and writes per walk.

For the second case, the bench pulses a stray request in the middle of a walk. It then checks that no extra memory read follows.

Random memory stalls and delayed acknowledges hold both handshakes open across several cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ_ROOT,
      ST_READ_LEAF,
      ST_UPDATE,
      ST_RESPOND
   } walk_state_t;

   typedef enum logic [1:0] {
      RS_OK        = 2'b00,
      RS_ROOT_MISS = 2'b01,
      RS_LEAF_MISS = 2'b10,
      RS_PROT      = 2'b11
   } walk_status_t;

   localparam int unsigned FLAG_PRESENT = 0;
   localparam int unsigned FLAG_WRITE   = 1;
   localparam int unsigned FLAG_REF     = 2;
   localparam int unsigned FLAG_DIRTY   = 3;
   localparam int unsigned FLAG_COUNT   = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned ROOT_IDX_W = 10,
   parameter int unsigned LEAF_IDX_W = 10,
   parameter int unsigned OFF_W      = 12,
   parameter int unsigned ENT_SH     = 2,
   parameter bit          WORD_ADDR  = 1'b1,
   parameter int unsigned MEM_AW     = 30
) (
   input  logic [VA_W-1:0]        vaddr,
   input  logic [PA_W-OFF_W-1:0]  root_frame,
   input  logic [PA_W-OFF_W-1:0]  sec_frame,
   input  logic [PA_W-OFF_W-1:0]  page_frame,
   output logic [MEM_AW-1:0]      root_maddr,
   output logic [MEM_AW-1:0]      leaf_maddr,
   output logic [PA_W-1:0]        paddr
);
   localparam int unsigned FRAME_W = PA_W - OFF_W;

   logic [ROOT_IDX_W-1:0] root_idx;
   logic [LEAF_IDX_W-1:0] leaf_idx;
   logic [OFF_W-1:0]      offset;

   assign root_idx = vaddr[VA_W-1 -: ROOT_IDX_W];
   assign leaf_idx = vaddr[OFF_W +: LEAF_IDX_W];
   assign offset   = vaddr[OFF_W-1:0];

   // every table fills one page, so base plus scaled index is a concatenation
   generate
      if (WORD_ADDR) begin : g_word
         assign root_maddr = {root_frame, root_idx};
         assign leaf_maddr = {sec_frame, leaf_idx};
      end else begin : g_byte
         assign root_maddr = {root_frame, root_idx, {ENT_SH{1'b0}}};
         assign leaf_maddr = {sec_frame, leaf_idx, {ENT_SH{1'b0}}};
      end
   endgenerate

   assign paddr = {page_frame, offset};

   initial begin
      assert (ROOT_IDX_W + LEAF_IDX_W + OFF_W == VA_W)
         else $error("index and offset widths must cover the virtual address");
      assert (ROOT_IDX_W + ENT_SH == OFF_W && LEAF_IDX_W + ENT_SH == OFF_W)
         else $error("each table must fill exactly one page");
      assert (MEM_AW == (WORD_ADDR ? PA_W - ENT_SH : PA_W))
         else $error("memory address width does not match addressing mode");
      assert (FRAME_W > 0) else $error("frame width must be positive");
   end

endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
   import ptw_pkg::*;
#(
   parameter int unsigned PTE_W = 32
) (
   input  logic [PTE_W-1:0] pte,
   input  logic             is_write,
   output logic             present,
   output logic             prot_fault,
   output logic             need_update,
   output logic [PTE_W-1:0] upd_pte
);
   logic [PTE_W-1:0] set_mask;

   always_comb begin
      set_mask = '0;
      set_mask[FLAG_REF]   = 1'b1;
      set_mask[FLAG_DIRTY] = is_write;
   end

   assign present     = pte[FLAG_PRESENT];
   assign prot_fault  = is_write & ~pte[FLAG_WRITE];
   assign upd_pte     = pte | set_mask;
   assign need_update = ((pte & set_mask) != set_mask);

   initial begin
      assert (PTE_W > FLAG_COUNT) else $error("entry too narrow for status flags");
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PA_W       = 32,
   parameter int unsigned PTE_W      = 32,
   parameter int unsigned ROOT_IDX_W = 10,
   parameter int unsigned LEAF_IDX_W = 10,
   parameter int unsigned OFF_W      = 12,
   parameter bit          WORD_ADDR  = 1'b1,
   localparam int unsigned FRAME_W   = PA_W - OFF_W,
   localparam int unsigned ENT_SH    = $clog2(PTE_W / 8),
   localparam int unsigned MEM_AW    = WORD_ADDR ? PA_W - ENT_SH : PA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic               req_write,
   input  logic [FRAME_W-1:0] req_root_frame,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic               mem_req_we,
   output logic [MEM_AW-1:0]  mem_req_addr,
   output logic [PTE_W-1:0]   mem_req_wdata,
   input  logic               mem_rsp_valid,
   input  logic [PTE_W-1:0]   mem_rsp_data,
   output logic               rsp_valid,
   input  logic               rsp_ack,
   output logic [1:0]         rsp_status,
   output logic [VA_W-1:0]    rsp_vaddr,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [PTE_W-1:0]   rsp_pte
);

   walk_state_t         state_q;
   logic                issued_q;
   logic [VA_W-1:0]     va_q;
   logic                wr_q;
   logic [FRAME_W-1:0]  root_frame_q;
   logic [FRAME_W-1:0]  sec_frame_q;
   logic [PTE_W-1:0]    final_pte_q;
   walk_status_t        status_q;

   logic [MEM_AW-1:0]   root_maddr;
   logic [MEM_AW-1:0]   leaf_maddr;
   logic [PA_W-1:0]     paddr;
   logic                leaf_present;
   logic                leaf_prot;
   logic                leaf_upd;
   logic [PTE_W-1:0]    leaf_new;
   logic                got_data;
   logic                mem_fire;

   ptw_addr_gen #(
      .VA_W       (VA_W),
      .PA_W       (PA_W),
      .ROOT_IDX_W (ROOT_IDX_W),
      .LEAF_IDX_W (LEAF_IDX_W),
      .OFF_W      (OFF_W),
      .ENT_SH     (ENT_SH),
      .WORD_ADDR  (WORD_ADDR),
      .MEM_AW     (MEM_AW)
   ) i_addr_gen (
      .vaddr      (va_q),
      .root_frame (root_frame_q),
      .sec_frame  (sec_frame_q),
      .page_frame (final_pte_q[PTE_W-1 -: FRAME_W]),
      .root_maddr (root_maddr),
      .leaf_maddr (leaf_maddr),
      .paddr      (paddr)
   );

   ptw_leaf_eval #(
      .PTE_W (PTE_W)
   ) i_leaf_eval (
      .pte         (mem_rsp_data),
      .is_write    (wr_q),
      .present     (leaf_present),
      .prot_fault  (leaf_prot),
      .need_update (leaf_upd),
      .upd_pte     (leaf_new)
   );

   assign req_ready     = (state_q == ST_IDLE);
   assign mem_req_valid = (((state_q == ST_READ_ROOT) || (state_q == ST_READ_LEAF)) && !issued_q)
                          || (state_q == ST_UPDATE);
   assign mem_req_we    = (state_q == ST_UPDATE);
   assign mem_req_addr  = (state_q == ST_READ_ROOT) ? root_maddr : leaf_maddr;
   assign mem_req_wdata = final_pte_q;
   assign mem_fire      = mem_req_valid && mem_req_ready;
   assign got_data      = issued_q && mem_rsp_valid;

   assign rsp_valid  = (state_q == ST_RESPOND);
   assign rsp_status = status_q;
   assign rsp_vaddr  = va_q;
   assign rsp_paddr  = paddr;
   assign rsp_pte    = final_pte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         issued_q     <= 1'b0;
         va_q         <= '0;
         wr_q         <= 1'b0;
         root_frame_q <= '0;
         sec_frame_q  <= '0;
         final_pte_q  <= '0;
         status_q     <= RS_OK;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q         <= req_vaddr;
                  wr_q         <= req_write;
                  root_frame_q <= req_root_frame;
                  issued_q     <= 1'b0;
                  state_q      <= ST_READ_ROOT;
               end
            end
            ST_READ_ROOT: begin
               if (mem_fire) issued_q <= 1'b1;
               if (got_data) begin
                  issued_q    <= 1'b0;
                  sec_frame_q <= mem_rsp_data[PTE_W-1 -: FRAME_W];
                  if (!mem_rsp_data[FLAG_PRESENT]) begin
                     final_pte_q <= mem_rsp_data;
                     status_q    <= RS_ROOT_MISS;
                     state_q     <= ST_RESPOND;
                  end else begin
                     state_q     <= ST_READ_LEAF;
                  end
               end
            end
            ST_READ_LEAF: begin
               if (mem_fire) issued_q <= 1'b1;
               if (got_data) begin
                  issued_q <= 1'b0;
                  if (!leaf_present) begin
                     final_pte_q <= mem_rsp_data;
                     status_q    <= RS_LEAF_MISS;
                     state_q     <= ST_RESPOND;
                  end else if (leaf_prot) begin
                     final_pte_q <= mem_rsp_data;
                     status_q    <= RS_PROT;
                     state_q     <= ST_RESPOND;
                  end else begin
                     final_pte_q <= leaf_new;
                     status_q    <= RS_OK;
                     state_q     <= leaf_upd ? ST_UPDATE : ST_RESPOND;
                  end
               end
            end
            ST_UPDATE: begin
               if (mem_fire) state_q <= ST_RESPOND;
            end
            ST_RESPOND: begin
               if (rsp_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_status) && $stable(rsp_paddr)
                               && $stable(rsp_pte) && $stable(rsp_vaddr));

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !rsp_valid && !mem_req_valid);

   // R9
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ack |=> !rsp_valid && req_ready);

   // R10
   mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                         && $stable(mem_req_we) && $stable(mem_req_wdata));

   // R6
   prot_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == RS_PROT |-> rsp_pte[FLAG_PRESENT] && !rsp_pte[FLAG_WRITE]);

   // R7
   wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_we |-> mem_req_wdata[FLAG_PRESENT] && mem_req_wdata[FLAG_REF]);

   // R7
   ok_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == RS_OK |-> rsp_pte[FLAG_REF] && (rsp_pte[FLAG_DIRTY] || !wr_q));

   // R4
   root_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_status == RS_ROOT_MISS |-> !rsp_pte[FLAG_PRESENT]);

endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic [19:0] req_root_frame = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic        mem_req_we;
   logic [29:0] mem_req_addr;
   logic [31:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic        rsp_ack = 1'b0;
   logic [1:0]  rsp_status;
   logic [31:0] rsp_vaddr;
   logic [31:0] rsp_paddr;
   logic [31:0] rsp_pte;

   always #2 clk = ~clk;

   pt_walker i_pt_walker (
      .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write, .req_root_frame,
      .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
      .mem_rsp_valid, .mem_rsp_data, .rsp_valid, .rsp_ack, .rsp_status,
      .rsp_vaddr, .rsp_paddr, .rsp_pte
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;

   logic [31:0] mem [int unsigned];
   logic [31:0] rq_data [$];
   int          rq_due  [$];

   typedef struct {
      logic [31:0] va;
      logic [1:0]  st;
      logic [31:0] pa;
      logic [31:0] pte;
      bit          chk_mem;
      logic [29:0] waddr;
      int          exp_rd;
      int          exp_wr;
      int          hold;
      string       tag;
   } exp_t;
   exp_t sb_q [$];

   function automatic logic [31:0] rd(input logic [29:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 32'h0;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // memory model: decides ready, records accepted accesses, returns reads later
   always @(negedge clk) begin
      cyc++;
      mem_rsp_valid = 1'b0;
      if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
         mem_rsp_valid = 1'b1;
         mem_rsp_data  = rq_data.pop_front();
         void'(rq_due.pop_front());
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_we) begin
            mem[int'(mem_req_addr)] = mem_req_wdata;
            wr_cnt++;
         end else begin
            rq_data.push_back(rd(mem_req_addr));
            rq_due.push_back(cyc + 1 + int'($urandom % 3));
            rd_cnt++;
         end
      end
   end

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid && rst_n) begin
            exp_t e;
            if (sb_q.size() == 0) begin
               chk("R9 unexpected answer", 32'(rsp_valid), 32'h0);
            end else begin
               e = sb_q.pop_front();
               chk({e.tag, " status"}, 32'(rsp_status), 32'(e.st));
               chk({e.tag, " vaddr"}, rsp_vaddr, e.va);
               chk({e.tag, " pte"}, rsp_pte, e.pte);
               if (e.st == 2'b00) chk({e.tag, " paddr"}, rsp_paddr, e.pa);
               chk({e.tag, " reads"}, 32'(rd_cnt), 32'(e.exp_rd));
               chk({e.tag, " writes"}, 32'(wr_cnt), 32'(e.exp_wr));
               if (e.chk_mem) chk({e.tag, " memory entry"}, rd(e.waddr), e.pte);
               for (int h = 0; h < e.hold; h++) begin
                  @(negedge clk);
                  chk({e.tag, " R9 held"}, {rsp_valid, 29'h0, rsp_status}, {1'b1, 29'h0, e.st});
               end
            end
            rsp_ack = 1'b1;
            @(negedge clk);
            rsp_ack = 1'b0;
            chk("R9 drop after ack", {31'h0, rsp_valid}, 32'h0);
         end
      end
   end

   task automatic walk(input logic [31:0] va, input bit we, input logic [19:0] root,
                       input int hold, input string tag);
      exp_t e;
      logic [31:0] re, le;
      logic [29:0] la;
      while (!req_ready || sb_q.size() != 0) @(negedge clk);
      e.va = va; e.hold = hold; e.tag = tag; e.chk_mem = 1'b0; e.waddr = '0;
      e.exp_wr = wr_cnt;
      re = rd({root, va[31:22]});
      if (!re[0]) begin
         e.st = 2'b01; e.pte = re; e.exp_rd = rd_cnt + 1;
      end else begin
         la = {re[31:12], va[21:12]};
         le = rd(la);
         e.exp_rd = rd_cnt + 2; e.chk_mem = 1'b1; e.waddr = la;
         if (!le[0]) begin
            e.st = 2'b10; e.pte = le;
         end else if (we && !le[1]) begin
            e.st = 2'b11; e.pte = le;
         end else begin
            e.st = 2'b00;
            e.pte = le | 32'h4 | (we ? 32'h8 : 32'h0);
            if (e.pte != le) e.exp_wr = wr_cnt + 1;
         end
      end
      e.pa = {e.pte[31:12], va[11:0]};
      sb_q.push_back(e);
      req_vaddr = va; req_write = we; req_root_frame = root; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      int rd_snap;
      mem[int'({20'h00010, 10'd0})]    = 32'h0002_0001;
      mem[int'({20'h00010, 10'd1023})] = 32'h0002_1001;
      mem[int'({20'h00010, 10'd5})]    = 32'h0099_9000;
      mem[int'({20'h00020, 10'd0})]    = 32'h0030_0003;
      mem[int'({20'h00020, 10'd1023})] = 32'h003F_F001;
      mem[int'({20'h00020, 10'd7})]    = 32'h0044_4002;
      mem[int'({20'h00021, 10'd1})]    = 32'h00AB_C00F;
      mem[int'({20'h00050, 10'd2})]    = 32'h0006_0001;
      for (int i = 0; i < 1024; i++) begin
         logic [31:0] v;
         v = {20'(32'h1000 + i), 8'h0,
              1'((i % 4) == 0), 1'((i % 5) == 0), 1'((i % 3) != 0), 1'((i % 7) != 0)};
         mem[int'({20'h00060, 10'(i)})] = v;
      end

      repeat (3) @(negedge clk);
      chk("reset req_ready", {31'h0, req_ready}, 32'h1);
      chk("reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("reset mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      walk(32'h0000_0123, 1'b0, 20'h00010, 0, "R1 R2 R3 R7 first read");
      walk(32'h0000_0123, 1'b0, 20'h00010, 0, "R8 repeat read");
      walk(32'h0000_0FFF, 1'b1, 20'h00010, 2, "R7 write sets dirty");
      walk(32'h0000_0FFF, 1'b1, 20'h00010, 0, "R8 repeat write");
      walk(32'h003F_F000, 1'b1, 20'h00010, 0, "R6 readonly write");
      walk(32'h003F_F000, 1'b0, 20'h00010, 0, "R3 readonly read");
      walk(32'h0140_0000, 1'b0, 20'h00010, 1, "R4 root absent");
      walk(32'h0000_7ABC, 1'b1, 20'h00010, 0, "R5 leaf absent");
      walk(32'hFFC0_1FFF, 1'b1, 20'h00010, 3, "R8 R9 flags preset");
      walk(32'h0000_0123, 1'b0, 20'h00050, 0, "R1 other root frame");

      // R9 stray request while busy
      walk(32'h0080_3456, 1'b0, 20'h00050, 0, "R9 walk under stray");
      @(negedge clk);
      req_vaddr = 32'h0000_0123; req_root_frame = 20'h00010; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready || sb_q.size() != 0) @(negedge clk);
      rd_snap = rd_cnt;
      repeat (6) @(negedge clk);
      chk("R9 stray request ignored", 32'(rd_cnt), 32'(rd_snap));

      for (int k = 0; k < 60; k++) begin
         logic [31:0] va;
         va = {10'd2, 10'($urandom % 1024), 12'($urandom)};
         walk(va, 1'($urandom % 2), 20'h00050, int'($urandom % 3), "R2 R3 R5 R6 R7 R8 sweep");
      end
      walk(32'hFFFF_FFFF, 1'b0, 20'h00050, 0, "R4 unset root entry");

      while (!req_ready || sb_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", sb_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule